// File: doc/BRIEF.md
# Password Security Lock Controller

This block decides, cycle by cycle, whether a storage device may run a host command, based on a password-protection state. Commands come in three classes. Commands that move no data always pass. Reads and writes are held back while the device is locked, and a scope setting chooses whether only writes or both reads and writes are held back. A separate comparator, outside this block, checks each password attempt and reports whether it matched and whether it was the user or the master password. This block turns those results into lock-state changes. It also counts consecutive wrong attempts. Once the limit is reached, it stops taking any attempt until a hard reset.

The security level sets what the master password can do. At High level, the master password unlocks the device just as the user password does. At Maximum level, the master password cannot unlock the device. A matching master attempt is honoured only when it carries an erase request, and security is then cleared when the external erase reports completion. Each verdict on a command appears one clock after the command is presented, as a one-cycle accept or abort pulse.

Top module: `seclock_top`

## Requirements
- R1: While the active-low reset is asserted, lock_state reads 5 (boot) and both verdict outputs are low. One clock after release, lock_state becomes 1 (locked) if stored_enabled is high, or 0 (open) if it is low.
- R2: A command of class 0 (non-data) gives cmd_accept high one cycle later in every state.
- R3: In state 1 (locked) or 3 (frozen), a read (class 1) is accepted when scope_rw is 0 and aborted when scope_rw is 1. A write (class 2) or class 3 is always aborted in these states. In states 4 (erasing) and 5 (boot), every data command is aborted. In states 0 (open) and 2 (unlocked), every command is accepted.
- R4: A verdict lasts exactly one cycle. An aborted command leaves lock_state unchanged, and cmd_accept and cmd_abort are never high together.
- R5: In state 1, a pw_check with pw_match high and pw_is_master low moves lock_state to 2.
- R6: With level_max low, a matching master attempt in state 1 moves lock_state to 2.
- R7: With level_max high, a matching master attempt in state 1 never moves lock_state to 2. If erase_req is low, it counts as a wrong attempt. If erase_req is high, lock_state goes to 4, and erase_done then moves it to 0. While in state 4, password attempts have no effect.
- R8: The ATT_LIMIT-th consecutive wrong attempt (default 5) moves lock_state from 1 to 3 and raises attempts_exhausted. In state 3, every attempt, including a correct one, is ignored until reset.
- R9: The wrong-attempt count clears on a successful unlock, on erase completion and on reset. Fewer than ATT_LIMIT wrong attempts followed by a correct one unlock the device.
- R10: set_pw moves state 0 to 2, and disable_req moves state 2 to 0 (disable_req wins if both are high). Both are ignored in states 1, 3 and 4. pw_check is ignored in states 0 and 2.
- R11: A command presented in the same cycle as a password attempt is judged on the state held before that attempt takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, asynchronous, active low |
| stored_enabled | input | 1 | Security-enabled status held in non-volatile storage, read on leaving boot |
| level_max | input | 1 | 0 = High level, 1 = Maximum level |
| scope_rw | input | 1 | 0 = lock blocks writes only, 1 = lock blocks reads and writes |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_class | input | 2 | 0 non-data, 1 read, 2 write, 3 reserved (treated as write) |
| pw_check | input | 1 | A password comparison result is presented |
| pw_is_master | input | 1 | The attempt used the master password |
| pw_match | input | 1 | The comparator found a match |
| erase_req | input | 1 | The attempt asks for a full erase |
| erase_done | input | 1 | The external erase has finished |
| set_pw | input | 1 | Set a user password and enable security |
| disable_req | input | 1 | Disable security |
| cmd_accept | output | 1 | One-cycle pulse: the previous command may run |
| cmd_abort | output | 1 | One-cycle pulse: the previous command is rejected |
| lock_state | output | 3 | 0 open, 1 locked, 2 unlocked, 3 frozen, 4 erasing, 5 boot |
| attempts_exhausted | output | 1 | High in the frozen state |

## Verification
A data command and a password attempt can arrive in the same cycle, so the command verdict and the unlock decision overlap. The bench presents a blocked write together with a correct user password while the device is locked. It expects an abort for that write, then state 2, and then an accept for the next write. A second overlap, the final allowed wrong attempt arriving together with a read, is judged the same way: the read follows the rules of the pre-freeze locked state while the state moves to frozen.

// File: rtl/seclock_pkg.sv
package seclock_pkg;

  typedef enum logic [2:0] {
    SL_OPEN     = 3'd0,
    SL_LOCKED   = 3'd1,
    SL_UNLOCKED = 3'd2,
    SL_FROZEN   = 3'd3,
    SL_ERASING  = 3'd4,
    SL_BOOT     = 3'd5
  } sl_state_e;

  typedef enum logic [1:0] {
    CMD_NONDATA = 2'd0,
    CMD_READ    = 2'd1,
    CMD_WRITE   = 2'd2,
    CMD_RSVD    = 2'd3
  } cmd_class_e;

endpackage

// File: rtl/seclock_attempts.sv
module seclock_attempts #(
  parameter int ATT_LIMIT = 5,
  parameter int CW        = $clog2(ATT_LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fail_i,
  input  logic          clear_i,
  output logic [CW-1:0] count_o,
  output logic          last_o
);

  localparam logic [CW-1:0] LAST_VAL = CW'(ATT_LIMIT - 1);
  localparam logic [CW-1:0] TOP_VAL  = CW'(ATT_LIMIT);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (clear_i) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (fail_i && (cnt_q != TOP_VAL)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign count_o = cnt_q;
  assign last_o  = (cnt_q == LAST_VAL);

endmodule

// File: rtl/seclock_fsm.sv
module seclock_fsm
  import seclock_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      stored_en_i,
  input  logic      level_max_i,
  input  logic      pw_check_i,
  input  logic      pw_master_i,
  input  logic      pw_match_i,
  input  logic      erase_req_i,
  input  logic      erase_done_i,
  input  logic      set_pw_i,
  input  logic      disable_i,
  input  logic      last_fail_i,
  output sl_state_e state_o,
  output logic      fail_o,
  output logic      clear_o
);

  sl_state_e state_q, state_d;
  logic      unlock_ok;
  logic      erase_ok;

  // master at Maximum level may only open the erase path
  assign unlock_ok = pw_match_i && (!pw_master_i || !level_max_i);
  assign erase_ok  = pw_match_i && pw_master_i && level_max_i && erase_req_i;

  always_comb begin
    state_d = state_q;
    fail_o  = 1'b0;
    clear_o = 1'b0;
    unique case (state_q)
      SL_BOOT: begin
        state_d = stored_en_i ? SL_LOCKED : SL_OPEN;
      end
      SL_OPEN: begin
        if (set_pw_i) state_d = SL_UNLOCKED;
      end
      SL_UNLOCKED: begin
        if (disable_i) state_d = SL_OPEN;
      end
      SL_LOCKED: begin
        if (pw_check_i) begin
          if (unlock_ok) begin
            state_d = SL_UNLOCKED;
            clear_o = 1'b1;
          end else if (erase_ok) begin
            state_d = SL_ERASING;
          end else begin
            fail_o = 1'b1;
            if (last_fail_i) state_d = SL_FROZEN;
          end
        end
      end
      SL_ERASING: begin
        if (erase_done_i) begin
          state_d = SL_OPEN;
          clear_o = 1'b1;
        end
      end
      SL_FROZEN: begin
        state_d = SL_FROZEN;
      end
      default: begin
        state_d = SL_BOOT;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SL_BOOT;
    end else begin
      state_q <= state_d;
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/seclock_gate.sv
module seclock_gate
  import seclock_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid_i,
  input  logic [1:0] cmd_class_i,
  input  sl_state_e  state_i,
  input  logic       scope_rw_i,
  output logic       accept_o,
  output logic       abort_o
);

  logic allowed;
  logic accept_d, abort_d;

  always_comb begin
    allowed = 1'b0;
    if (cmd_class_i == CMD_NONDATA) begin
      allowed = 1'b1;
    end else begin
      unique case (state_i)
        SL_OPEN, SL_UNLOCKED: allowed = 1'b1;
        SL_LOCKED, SL_FROZEN: allowed = (cmd_class_i == CMD_READ) && !scope_rw_i;
        default:              allowed = 1'b0;
      endcase
    end
    accept_d = cmd_valid_i && allowed;
    abort_d  = cmd_valid_i && !allowed;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accept_o <= 1'b0;
      abort_o  <= 1'b0;
    end else begin
      accept_o <= accept_d;
      abort_o  <= abort_d;
    end
  end

endmodule

// File: rtl/seclock_top.sv
module seclock_top
  import seclock_pkg::*;
#(
  parameter int ATT_LIMIT = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stored_enabled,
  input  logic       level_max,
  input  logic       scope_rw,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_class,
  input  logic       pw_check,
  input  logic       pw_is_master,
  input  logic       pw_match,
  input  logic       erase_req,
  input  logic       erase_done,
  input  logic       set_pw,
  input  logic       disable_req,
  output logic       cmd_accept,
  output logic       cmd_abort,
  output logic [2:0] lock_state,
  output logic       attempts_exhausted
);

  localparam int CNT_W = $clog2(ATT_LIMIT + 1);

  sl_state_e        state;
  logic             fail_evt;
  logic             clear_evt;
  logic             last_fail;
  logic [CNT_W-1:0] attempt_cnt;

  seclock_attempts #(
    .ATT_LIMIT (ATT_LIMIT),
    .CW        (CNT_W)
  ) u_attempts (
    .clk     (clk),
    .rst_n   (rst_n),
    .fail_i  (fail_evt),
    .clear_i (clear_evt),
    .count_o (attempt_cnt),
    .last_o  (last_fail)
  );

  seclock_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .stored_en_i  (stored_enabled),
    .level_max_i  (level_max),
    .pw_check_i   (pw_check),
    .pw_master_i  (pw_is_master),
    .pw_match_i   (pw_match),
    .erase_req_i  (erase_req),
    .erase_done_i (erase_done),
    .set_pw_i     (set_pw),
    .disable_i    (disable_req),
    .last_fail_i  (last_fail),
    .state_o      (state),
    .fail_o       (fail_evt),
    .clear_o      (clear_evt)
  );

  seclock_gate u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid_i (cmd_valid),
    .cmd_class_i (cmd_class),
    .state_i     (state),
    .scope_rw_i  (scope_rw),
    .accept_o    (cmd_accept),
    .abort_o     (cmd_abort)
  );

  assign lock_state         = state;
  assign attempts_exhausted = (state == SL_FROZEN);

endmodule

// File: rtl/seclock_checker.sv
module seclock_checker #(
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic [1:0]    cmd_class,
  input logic          pw_check,
  input logic          pw_is_master,
  input logic          pw_match,
  input logic          level_max,
  input logic          cmd_accept,
  input logic          cmd_abort,
  input logic [2:0]    lock_state,
  input logic [CW-1:0] fail_cnt
);

  AST_VERDICT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_accept && cmd_abort)); // R4

  AST_ABORT_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_abort |-> $past(cmd_valid)); // R4

  AST_NONDATA_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_class == 2'd0) |=> cmd_accept); // R2

  AST_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_class == 2'd2 && lock_state != 3'd0 && lock_state != 3'd2)
      |=> cmd_abort); // R3

  AST_MAX_MASTER_NO_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_state == 3'd1 && pw_check && pw_is_master && pw_match && level_max)
      |=> lock_state != 3'd2); // R7

  AST_FROZEN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_state == 3'd3) |=> (lock_state == 3'd3)); // R8

  AST_UNLOCK_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_state == 3'd2) |-> (fail_cnt == '0)); // R9

endmodule

bind seclock_top seclock_checker #(.CW(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_valid    (cmd_valid),
  .cmd_class    (cmd_class),
  .pw_check     (pw_check),
  .pw_is_master (pw_is_master),
  .pw_match     (pw_match),
  .level_max    (level_max),
  .cmd_accept   (cmd_accept),
  .cmd_abort    (cmd_abort),
  .lock_state   (lock_state),
  .fail_cnt     (attempt_cnt)
);

// File: tb/seclock_top_bench.sv
module seclock_top_bench;

  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 5;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       stored_enabled, level_max, scope_rw;
  logic       cmd_valid;
  logic [1:0] cmd_class;
  logic       pw_check, pw_is_master, pw_match, erase_req, erase_done;
  logic       set_pw, disable_req;
  logic       cmd_accept, cmd_abort;
  logic [2:0] lock_state;
  logic       attempts_exhausted;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  seclock_top #(.ATT_LIMIT(LIMIT)) u_seclock_top (
    .clk                (clk),
    .rst_n              (rst_n),
    .stored_enabled     (stored_enabled),
    .level_max          (level_max),
    .scope_rw           (scope_rw),
    .cmd_valid          (cmd_valid),
    .cmd_class          (cmd_class),
    .pw_check           (pw_check),
    .pw_is_master       (pw_is_master),
    .pw_match           (pw_match),
    .erase_req          (erase_req),
    .erase_done         (erase_done),
    .set_pw             (set_pw),
    .disable_req        (disable_req),
    .cmd_accept         (cmd_accept),
    .cmd_abort          (cmd_abort),
    .lock_state         (lock_state),
    .attempts_exhausted (attempts_exhausted)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input int act, input int exp, input string req, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    cmd_valid = 0; cmd_class = 0; pw_check = 0; pw_is_master = 0;
    pw_match = 0; erase_req = 0; erase_done = 0; set_pw = 0; disable_req = 0;
  endtask

  task automatic do_reset(input logic en);
    idle_inputs();
    stored_enabled = en;
    rst_n = 0;
    tick(); tick();
    chk(lock_state, 5, "R1", "state in reset");
    chk(cmd_accept | cmd_abort, 0, "R1", "verdicts in reset");
    rst_n = 1;
    tick();
    chk(lock_state, en ? 1 : 0, "R1", "state after boot");
    chk(attempts_exhausted, 0, "R1", "exhausted after reset");
  endtask

  // command with verdict check, one-cycle pulse check and state-hold check
  task automatic issue_cmd(input logic [1:0] cls, input bit exp_ok, input string req);
    logic [2:0] st;
    st = lock_state;
    cmd_valid = 1; cmd_class = cls;
    tick();
    cmd_valid = 0;
    chk(cmd_accept, exp_ok, req, $sformatf("accept class %0d", cls));
    chk(cmd_abort, !exp_ok, req, $sformatf("abort class %0d", cls));
    chk(lock_state, st, "R4", "state held over command");
    tick();
    chk(cmd_accept | cmd_abort, 0, "R4", "verdict one cycle");
  endtask

  task automatic attempt(input bit master, input bit match, input bit erase);
    pw_check = 1; pw_is_master = master; pw_match = match; erase_req = erase;
    tick();
    pw_check = 0; pw_is_master = 0; pw_match = 0; erase_req = 0;
  endtask

  task automatic t_reset_open();
    do_reset(0);
    scope_rw = 1;
    issue_cmd(2'd1, 1, "R3");
    issue_cmd(2'd2, 1, "R3");
    issue_cmd(2'd0, 1, "R2");
    attempt(0, 0, 0);
    chk(lock_state, 0, "R10", "pw_check ignored when open");
    set_pw = 1; tick(); set_pw = 0;
    chk(lock_state, 2, "R10", "set_pw opens to unlocked");
    attempt(0, 0, 0);
    chk(lock_state, 2, "R10", "pw_check ignored when unlocked");
    set_pw = 1; disable_req = 1; tick(); set_pw = 0; disable_req = 0;
    chk(lock_state, 0, "R10", "disable wins");
  endtask

  task automatic t_scope();
    do_reset(1);
    scope_rw = 0;
    issue_cmd(2'd0, 1, "R2");
    issue_cmd(2'd1, 1, "R3");
    issue_cmd(2'd2, 0, "R3");
    issue_cmd(2'd3, 0, "R3");
    scope_rw = 1;
    issue_cmd(2'd1, 0, "R3");
    issue_cmd(2'd0, 1, "R2");
    set_pw = 1; tick(); set_pw = 0;
    chk(lock_state, 1, "R10", "set_pw ignored when locked");
    disable_req = 1; tick(); disable_req = 0;
    chk(lock_state, 1, "R10", "disable ignored when locked");
    attempt(0, 1, 0);
    chk(lock_state, 2, "R5", "user unlock");
    issue_cmd(2'd2, 1, "R5");
  endtask

  task automatic t_master_high();
    level_max = 0;
    do_reset(1);
    attempt(1, 1, 0);
    chk(lock_state, 2, "R6", "master unlock at High");
  endtask

  task automatic t_master_max();
    level_max = 1;
    scope_rw = 0;
    do_reset(1);
    attempt(1, 1, 0);
    chk(lock_state, 1, "R7", "master without erase at Maximum");
    attempt(0, 1, 0);
    chk(lock_state, 2, "R7", "user still unlocks at Maximum");
    do_reset(1);
    attempt(1, 1, 1);
    chk(lock_state, 4, "R7", "master with erase");
    issue_cmd(2'd1, 0, "R3");
    issue_cmd(2'd2, 0, "R3");
    issue_cmd(2'd0, 1, "R2");
    attempt(0, 1, 0);
    chk(lock_state, 4, "R7", "attempt ignored while erasing");
    set_pw = 1; tick(); set_pw = 0;
    chk(lock_state, 4, "R10", "set_pw ignored while erasing");
    erase_done = 1; tick(); erase_done = 0;
    chk(lock_state, 0, "R7", "erase complete opens");
    level_max = 0;
  endtask

  task automatic t_freeze();
    scope_rw = 0;
    do_reset(1);
    for (int i = 0; i < LIMIT - 1; i++) attempt(0, 0, 0);
    chk(lock_state, 1, "R8", "locked before limit");
    chk(attempts_exhausted, 0, "R8", "not exhausted before limit");
    attempt(0, 0, 0);
    chk(lock_state, 3, "R8", "frozen at limit");
    chk(attempts_exhausted, 1, "R8", "exhausted at limit");
    attempt(0, 1, 0);
    chk(lock_state, 3, "R8", "correct user ignored when frozen");
    attempt(1, 1, 0);
    chk(lock_state, 3, "R8", "correct master ignored when frozen");
    issue_cmd(2'd1, 1, "R3");
    issue_cmd(2'd2, 0, "R3");
    do_reset(1);
    attempt(0, 1, 0);
    chk(lock_state, 2, "R8", "reset leaves frozen");
  endtask

  task automatic t_count_clear();
    level_max = 1;
    do_reset(1);
    for (int i = 0; i < LIMIT - 2; i++) attempt(0, 0, 0);
    attempt(1, 1, 0);  // counts as wrong at Maximum
    chk(lock_state, 1, "R9", "still locked below limit");
    attempt(0, 1, 0);
    chk(lock_state, 2, "R9", "unlock below limit");
    level_max = 0;
  endtask

  task automatic t_same_cycle();
    scope_rw = 1;
    do_reset(1);
    cmd_valid = 1; cmd_class = 2'd2; pw_check = 1; pw_match = 1;
    tick();
    idle_inputs();
    chk(cmd_abort, 1, "R11", "write judged on old state");
    chk(lock_state, 2, "R11", "unlock same cycle");
    tick();
    issue_cmd(2'd2, 1, "R11");
    scope_rw = 0;
    do_reset(1);
    for (int i = 0; i < LIMIT - 1; i++) attempt(0, 0, 0);
    cmd_valid = 1; cmd_class = 2'd1; pw_check = 1;
    tick();
    idle_inputs();
    chk(cmd_accept, 1, "R11", "read judged on pre-freeze state");
    chk(lock_state, 3, "R11", "freeze same cycle");
  endtask

  initial begin
    idle_inputs();
    rst_n = 0; stored_enabled = 0; level_max = 0; scope_rw = 0;
    t_reset_open();
    t_scope();
    t_master_high();
    t_master_max();
    t_freeze();
    t_count_clear();
    t_same_cycle();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule